// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a 32.768 kHz oscillator into a one-pulse-per-second strobe. Most seconds last exactly the nominal number of oscillator cycles. A signed trim code lets the block stretch or shrink a few seconds by one whole count each, so that the average tick rate moves by a fixed number of parts per million. The oscillator itself is never changed. One count out of 32768 is about 30.5 ppm. Spreading one such count over a three-second window therefore gives a step of about 10 ppm.

A small state machine sequences the seconds. It has three states:
- `ST_LEAD` is the single unadjusted second that follows reset.
- `ST_ADJ` is a second whose terminal count has been moved by one.
- `ST_PLAIN` is an unadjusted second inside a window.

Every transition fires on the seconds strobe:
- **window open**: from `ST_LEAD`, or from the last second of a window, to `ST_ADJ` when the freshly sampled magnitude is non-zero, otherwise to `ST_PLAIN`.
- **adjust continue**: `ST_ADJ` to `ST_ADJ` while the next second index is still below the magnitude.
- **adjust done**: `ST_ADJ` to `ST_PLAIN` once the next second index reaches the magnitude.
- **plain continue**: `ST_PLAIN` to `ST_PLAIN` within a window.

A divider counts from zero up to the terminal count that the current state selects. The strobe is raised in the cycle where the count equals that terminal count.

Top module: `trimmed_sec_prescaler`

## Requirements
- R1: While `rst_n` is low, `div_count` is 0 and `sec_tick` is 0.
- R2: After reset is released, the first second is unadjusted whatever the trim code. Its strobe comes in the cycle where `div_count` reaches N-1, which is N cycles after release.
- R3: In an unadjusted second, `div_count` rises by one each cycle from 0 to N-1. `sec_tick` is high only in the N-1 cycle, and the next cycle shows count 0.
- R4: A positively adjusted second ends at terminal count N and lasts N+1 cycles.
- R5: A negatively adjusted second ends at terminal count N-2 and lasts N-1 cycles.
- R6: The trim code is read as follows. Bit 2 is the sign, with 0 meaning more counts and 1 meaning fewer. Bit 1 is worth 20 ppm and bit 0 is worth 10 ppm. The magnitude `trim[1:0]` gives the number of adjusted seconds per window. A magnitude of 0 gives no correction for either sign.
- R7: With a magnitude of m, the first m seconds of each three-second window are adjusted and the rest are unadjusted.
- R8: The trim code is sampled only on the edge that ends the lead-in second or the last second of a window. A change at any other time has no effect until the next window opens.
- R9: `sec_tick` is never high in two consecutive cycles.
- R10: `div_count` never exceeds N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trim | input | 3 | Sign and magnitude trim code |
| sec_tick | output | 1 | One-cycle seconds strobe |
| div_count | output | $clog2(OSC_COUNTS+1) | Current divider count |

## Verification
The bench builds the block with `OSC_COUNTS` = 16 and `WINDOW_SECS` = 3. Each second is therefore 15 to 17 cycles long. Hundreds of complete windows, and every one of the eight trim codes, fit in a short run. The small count also places trim changes on the strobe edge itself, and on cycles just before and after it, often enough to check the window-sampling rule. These are the same behaviours that matter at 32768.

// File: rtl/tsp_pkg.sv
`timescale 1ns/1ps
package tsp_pkg;
    localparam int STEP_W = 2;

    typedef enum logic [1:0] {
        ST_LEAD  = 2'd0,
        ST_ADJ   = 2'd1,
        ST_PLAIN = 2'd2
    } sec_state_t;

    typedef struct packed {
        logic              slow;   // 1: remove counts, 0: add counts
        logic [STEP_W-1:0] steps;  // adjusted seconds per window
    } trim_t;
endpackage

// File: rtl/tsp_trim_decode.sv
`timescale 1ns/1ps
module tsp_trim_decode
    import tsp_pkg::*;
(
    input  logic [STEP_W:0] code,
    output trim_t           trim
);
    always_comb begin
        trim.steps = code[STEP_W-1:0];
        // zero magnitude carries no direction
        trim.slow  = code[STEP_W] && (code[STEP_W-1:0] != '0);
    end
endmodule

// File: rtl/tsp_window_fsm.sv
`timescale 1ns/1ps
module tsp_window_fsm
    import tsp_pkg::*;
#(
    parameter int OSC_COUNTS  = 32768,
    parameter int WINDOW_SECS = 3,
    parameter int CNT_W       = $clog2(OSC_COUNTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  trim_t            trim_new,
    output logic [CNT_W-1:0] term
);
    localparam int IDX_W = (WINDOW_SECS > 1) ? $clog2(WINDOW_SECS) : 1;
    localparam logic [CNT_W-1:0] TERM_NOM   = CNT_W'(OSC_COUNTS - 1);
    localparam logic [CNT_W-1:0] TERM_LONG  = CNT_W'(OSC_COUNTS);
    localparam logic [CNT_W-1:0] TERM_SHORT = CNT_W'(OSC_COUNTS - 2);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(WINDOW_SECS - 1);

    sec_state_t       state, next_state;
    logic [IDX_W-1:0] idx, next_idx;
    trim_t            held, next_held;
    logic             win_last;

    assign win_last = (state == ST_LEAD) || (idx == IDX_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LEAD;
            idx   <= '0;
            held  <= '0;
        end else begin
            state <= next_state;
            idx   <= next_idx;
            held  <= next_held;
        end
    end

    // transitions
    always_comb begin
        next_state = state;
        next_idx   = idx;
        next_held  = held;
        if (tick) begin
            if (win_last) begin
                next_idx   = '0;
                next_held  = trim_new;
                next_state = (trim_new.steps != '0) ? ST_ADJ : ST_PLAIN;
            end else begin
                next_idx   = idx + 1'b1;
                next_state = ((int'(idx) + 1) < int'(held.steps)) ? ST_ADJ : ST_PLAIN;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADJ:   term = held.slow ? TERM_SHORT : TERM_LONG;
            ST_LEAD:  term = TERM_NOM;
            ST_PLAIN: term = TERM_NOM;
            default:  term = TERM_NOM;
        endcase
    end

    p_held_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(held));
    p_lead_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && tick) |=> (state != ST_LEAD));
    p_no_lead_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LEAD) |=> (state != ST_LEAD));
    p_first_adjusted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && win_last && trim_new.steps != '0) |=> (state == ST_ADJ));
endmodule

// File: rtl/tsp_divider.sv
`timescale 1ns/1ps
module tsp_divider #(
    parameter int OSC_COUNTS = 32768,
    parameter int CNT_W      = $clog2(OSC_COUNTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] count,
    output logic             tick
);
    assign tick = (count == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= '0;
        else           count <= count + 1'b1;
    end

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == '0));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (count == $past(count) + 1'b1));
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= OSC_COUNTS);
endmodule

// File: rtl/trimmed_sec_prescaler.sv
`timescale 1ns/1ps
module trimmed_sec_prescaler
    import tsp_pkg::*;
#(
    parameter int OSC_COUNTS  = 32768,
    parameter int WINDOW_SECS = 3,
    localparam int CNT_W      = $clog2(OSC_COUNTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       trim,
    output logic             sec_tick,
    output logic [CNT_W-1:0] div_count
);
    trim_t            trim_dec;
    logic [CNT_W-1:0] term;

    tsp_trim_decode u_decode (
        .code (trim),
        .trim (trim_dec)
    );

    tsp_window_fsm #(
        .OSC_COUNTS  (OSC_COUNTS),
        .WINDOW_SECS (WINDOW_SECS),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .trim_new (trim_dec),
        .term     (term)
    );

    tsp_divider #(
        .OSC_COUNTS (OSC_COUNTS),
        .CNT_W      (CNT_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .term  (term),
        .count (div_count),
        .tick  (sec_tick)
    );

    p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);
endmodule

// File: tb/trimmed_sec_prescaler_test.sv
`timescale 1ns/1ps
module trimmed_sec_prescaler_test;
    localparam int N  = 16;
    localparam int W  = 3;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    trim = 3'b000;
    logic          sec_tick;
    logic [CW-1:0] div_count;

    int  checks = 0, fails = 0;
    bit  done = 0;
    // reference model state
    int  ec = 0, widx = 0, wmag = 0;
    bit  wneg = 0, in_lead = 1, prev_tick = 0;
    logic [2:0] wcode = 3'b000;

    always #4 clk = ~clk;

    trimmed_sec_prescaler #(.OSC_COUNTS(N), .WINDOW_SECS(W)) uut (
        .clk(clk), .rst_n(rst_n), .trim(trim),
        .sec_tick(sec_tick), .div_count(div_count)
    );

    function automatic int exp_term(bit lead, int idx, int mag, bit neg);
        if (lead) return N - 1;       // R2
        if (idx < mag) return neg ? N - 2 : N;  // R4 R5 R7
        return N - 1;                 // R3
    endfunction

    function automatic string tag_of();
        if (in_lead) return "R2";
        if (trim != wcode) return "R8";
        if (widx < wmag) return wneg ? "R5" : "R4";
        if (wmag == 0 && wcode[2]) return "R6";
        if (wmag != 0) return "R7";
        return "R3";
    endfunction

    task automatic step(bit allow_change);
        int t;
        bit et;
        t  = exp_term(in_lead, widx, wmag, wneg);
        et = (ec == t);
        checks++;
        if (int'(div_count) != ec || sec_tick !== et) begin
            fails++;
            $display("FAIL %s: count=%0d tick=%0b, expected count=%0d tick=%0b",
                     tag_of(), div_count, sec_tick, ec, et);
        end
        if (sec_tick) begin
            checks++;
            if (prev_tick) begin
                fails++;
                $display("FAIL R9: tick=1 after tick=1, expected 0");
            end
            checks++;
            if (int'(div_count) > N) begin
                fails++;
                $display("FAIL R10: count=%0d, expected <= %0d", div_count, N);
            end
        end
        prev_tick = sec_tick;
        if (allow_change && $urandom_range(0, 11) == 0)
            trim = 3'($urandom_range(0, 7));
        if (et) begin
            ec = 0;
            if (in_lead || widx == W - 1) begin
                in_lead = 0;
                widx    = 0;
                wcode   = trim;
                wmag    = int'(trim[1:0]);   // R6
                wneg    = trim[2];
            end else begin
                widx++;
            end
        end else begin
            ec++;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if (div_count !== '0 || sec_tick !== 1'b0) begin
            fails++;
            $display("FAIL R1: count=%0d tick=%0b, expected count=0 tick=0",
                     div_count, sec_tick);
        end
        ec = 0; widx = 0; wmag = 0; wneg = 0; in_lead = 1; prev_tick = 0;
        wcode = trim;
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // directed: each trim code held over several windows
        for (int code = 0; code < 8; code++) begin
            trim = 3'(code);
            do_reset();
            for (int c = 0; c < (N + 1) * W * 3 + N; c++) step(1'b0);
        end
        // random trim changes at arbitrary cycles
        trim = 3'b011;
        do_reset();
        for (int c = 0; c < 6000; c++) step(1'b1);
        // reset in the middle of an adjusted window
        trim = 3'b111;
        do_reset();
        for (int c = 0; c < N + 5; c++) step(1'b0);
        do_reset();
        for (int c = 0; c < (N + 1) * W * 2; c++) step(1'b1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule